// File: doc/BRIEF.md
# Indirect Register Load/Store Engine

This engine moves data between one thread's 64-entry register file and a byte-addressed local memory. It does not take addresses from the instruction. Each instruction names a base register and a 16-bit offset half-register. The byte address is the base value times sixteen plus that offset. Transfers are 8, 16, 32 or 128 bits wide. The address is aligned down to the transfer size before the access. Once the address has been formed, the offset half-register can be advanced by 2, 4 or 16 bytes. A second store flavour sends one 32-bit register to a memory-mapped register window.

The engine reads and writes registers through a single read port and a single byte-enabled write port. Memory is reached through a 128-bit line-wide request port and a response port. Load data comes back at an unknown later time. While it is outstanding, a pending flag stays set, and the engine accepts no new instruction until the returned data has been written into the registers.

Top module: `ind_xfer_unit`

## Requirements
- R1: A load has opcode 0x49 in bits [31:24]. Its size code sits in [23:22] (0 = 128-bit, 1 = 32-bit, 2 = 16-bit, 3 = 8-bit), the offset half index in [21:14], the increment code in [13:12], the data register in [11:6] and the base register in [5:0]. It reads memory at byte address base*16 + offset, and a 32-bit load replaces the whole data register.
- R2: Offset half index 2n selects bits [15:0] of register n, and index 2n+1 selects bits [31:16]. Only the low 7 bits of the load's 8-bit half index are used.
- R3: Increment codes 0, 1, 2 and 3 add 0, 2, 4 and 16 to the offset half-register, wrapping at 16 bits. The access uses the value from before the increment, and the other half of that register is unchanged.
- R4: Before the access, the address is aligned down to 16 bytes for 128-bit, 4 bytes for 32-bit and 2 bytes for 16-bit transfers. An 8-bit transfer is not aligned.
- R5: A 128-bit transfer clears the low two bits of the data register index. It moves four consecutive registers, and register k holds bytes 4k..4k+3 of the 16-byte line, least significant byte first.
- R6: A 16-bit load writes only bits [15:0] of the data register, and an 8-bit load writes only bits [7:0]. The other bits keep their value.
- R7: A local store has opcode 0x66 with bit [23] = 1. Its size code is {[22],[21]} with the load's encoding, and its offset index is [20:14]. It writes the low bytes of the data register, or four registers for 128-bit, at the aligned address with byte strobes, and leaves every other byte unchanged.
- R8: A window store has opcode 0x66 with [23] = 0 and [22] = 1. It writes the full data register to WIN_BASE OR ({base + (offset >> 4)}[19:2] << 2), and then applies the increment code.
- R9: Every accepted load, local store or window store keeps instr_ready low for at least 3 cycles.
- R10: load_pending rises in the cycle after a load request. It stays high until the last register write of that load, and instr_ready stays low while it is high.
- R11: Opcode 0x66 with [23:22] = 0, and every other opcode, is accepted with no memory request, no window write and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr | input | 32 | Instruction word |
| instr_ready | output | 1 | Engine idle, instruction taken when valid |
| rf_ra | output | 6 | Register read index |
| rf_rd | input | 32 | Register read data (combinational) |
| rf_we | output | 1 | Register write strobe |
| rf_wa | output | 6 | Register write index |
| rf_wd | output | 32 | Register write data |
| rf_wbe | output | 4 | Register write byte enables |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Aligned byte address |
| mem_be | output | 16 | Byte strobes within the 16-byte line |
| mem_wdata | output | 128 | Write data, line-positioned |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 128 | Read response: the full 16-byte line |
| mmio_we | output | 1 | Window write strobe |
| mmio_addr | output | 32 | Window write address |
| mmio_wdata | output | 32 | Window write data |
| load_pending | output | 1 | Load data not yet written back |

## Verification
The bench builds the engine with the default window base 0xFFB00000. Because that base has no bits in [19:2], the kept address bits appear unaltered in the window address, so an error in the window arithmetic cannot be hidden by the OR. The memory model is 4 KiB and is filled so that each byte equals its own address within the first 256 bytes. Every aligned word therefore has a value that can be worked out by hand, and a wrong alignment, lane or offset half shows up as a different value. A wrapped offset lands back inside the modelled space, and the memory model's response latency is varied to stretch the pending window.

// File: rtl/ind_xfer_pkg.sv
package ind_xfer_pkg;
    localparam logic [7:0] OPC_LOAD  = 8'h49;
    localparam logic [7:0] OPC_STORE = 8'h66;
    localparam int RIDX_W    = 6;
    localparam int LINE_W    = 128;
    localparam int LINE_B    = LINE_W / 8;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;

    typedef enum logic [2:0] {
        S_IDLE, S_BASE, S_OFFS, S_DATA, S_ISSUE, S_WAIT, S_WB
    } state_e;

    typedef enum logic [1:0] {
        K_LOAD, K_STMEM, K_STWIN
    } kind_e;

    localparam logic [1:0] SZ_LINE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_HALF = 2'd2;
    localparam logic [1:0] SZ_BYTE = 2'd3;
endpackage

// File: rtl/ind_xfer_agen.sv
module ind_xfer_agen
    import ind_xfer_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'hFFB0_0000
) (
    input  logic [WORD_W-1:0] base,
    input  logic [HALF_W-1:0] off,
    input  logic [1:0]        size,
    input  logic [1:0]        inc,
    output logic [WORD_W-1:0] addr,
    output logic [HALF_W-1:0] off_next,
    output logic [WORD_W-1:0] win_addr
);
    logic [WORD_W-1:0] raw;
    logic [WORD_W-1:0] wsum;
    logic [HALF_W-1:0] step;

    always_comb begin
        raw = {base[WORD_W-5:0], 4'b0000} + {{(WORD_W-HALF_W){1'b0}}, off};
        unique case (size)
            SZ_LINE: addr = {raw[WORD_W-1:4], 4'b0000};
            SZ_WORD: addr = {raw[WORD_W-1:2], 2'b00};
            SZ_HALF: addr = {raw[WORD_W-1:1], 1'b0};
            default: addr = raw;
        endcase
        unique case (inc)
            2'd0:    step = 16'd0;
            2'd1:    step = 16'd2;
            2'd2:    step = 16'd4;
            default: step = 16'd16;
        endcase
        off_next = off + step;
        wsum     = base + {{(WORD_W-HALF_W+4){1'b0}}, off[HALF_W-1:4]};
        win_addr = WIN_BASE | {12'h000, wsum[19:2], 2'b00};
    end
endmodule

// File: rtl/ind_xfer_lane.sv
module ind_xfer_lane
    import ind_xfer_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [3:0]        addr_lo,
    input  logic [1:0]        k,
    input  logic [LINE_W-1:0] line,
    output logic [WORD_W-1:0] wb_data,
    output logic [3:0]        wb_be,
    output logic [LINE_W-1:0] st_data,
    output logic [LINE_B-1:0] st_be
);
    logic [WORD_W-1:0] w_sel;
    logic [HALF_W-1:0] h_sel;
    logic [7:0]        b_sel;

    always_comb begin
        w_sel = line[{addr_lo[3:2], 5'b0} +: WORD_W];
        h_sel = line[{addr_lo[3:1], 4'b0} +: HALF_W];
        b_sel = line[{addr_lo, 3'b0} +: 8];
        unique case (size)
            SZ_LINE: begin
                wb_data = line[{k, 5'b0} +: WORD_W];
                wb_be   = 4'hF;
                st_data = line;
                st_be   = {LINE_B{1'b1}};
            end
            SZ_WORD: begin
                wb_data = w_sel;
                wb_be   = 4'hF;
                st_data = {4{line[WORD_W-1:0]}};
                st_be   = 16'h000F << {addr_lo[3:2], 2'b00};
            end
            SZ_HALF: begin
                wb_data = {16'h0000, h_sel};
                wb_be   = 4'h3;
                st_data = {8{line[HALF_W-1:0]}};
                st_be   = 16'h0003 << {addr_lo[3:1], 1'b0};
            end
            default: begin
                wb_data = {24'h000000, b_sel};
                wb_be   = 4'h1;
                st_data = {16{line[7:0]}};
                st_be   = 16'h0001 << addr_lo;
            end
        endcase
    end
endmodule

// File: rtl/ind_xfer_unit.sv
module ind_xfer_unit
    import ind_xfer_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'hFFB0_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [31:0]          instr,
    output logic                 instr_ready,
    output logic [RIDX_W-1:0]    rf_ra,
    input  logic [WORD_W-1:0]    rf_rd,
    output logic                 rf_we,
    output logic [RIDX_W-1:0]    rf_wa,
    output logic [WORD_W-1:0]    rf_wd,
    output logic [3:0]           rf_wbe,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [31:0]          mem_addr,
    output logic [LINE_B-1:0]    mem_be,
    output logic [LINE_W-1:0]    mem_wdata,
    input  logic                 mem_rvalid,
    input  logic [LINE_W-1:0]    mem_rdata,
    output logic                 mmio_we,
    output logic [31:0]          mmio_addr,
    output logic [WORD_W-1:0]    mmio_wdata,
    output logic                 load_pending
);
    typedef struct packed {
        state_e            st;
        kind_e             kind;
        logic [1:0]        size;
        logic [1:0]        inc;
        logic [6:0]        offidx;
        logic [RIDX_W-1:0] dreg;
        logic [RIDX_W-1:0] areg;
        logic [WORD_W-1:0] base;
        logic [31:0]       addr;
        logic [31:0]       waddr;
        logic [1:0]        k;
        logic [LINE_W-1:0] sbuf;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [HALF_W-1:0] off_val;
    logic [31:0]       ag_addr, ag_win;
    logic [HALF_W-1:0] ag_next;
    logic [WORD_W-1:0] ln_wb;
    logic [3:0]        ln_wbe;
    logic [LINE_W-1:0] ln_st;
    logic [LINE_B-1:0] ln_sbe;
    logic [RIDX_W-1:0] dreg_k;

    assign off_val = ctx_q.offidx[0] ? rf_rd[31:16] : rf_rd[15:0];
    assign dreg_k  = (ctx_q.size == SZ_LINE) ? {ctx_q.dreg[5:2], ctx_q.k} : ctx_q.dreg;

    ind_xfer_agen #(.WIN_BASE(WIN_BASE)) u_agen (
        .base     (ctx_q.base),
        .off      (off_val),
        .size     (ctx_q.size),
        .inc      (ctx_q.inc),
        .addr     (ag_addr),
        .off_next (ag_next),
        .win_addr (ag_win)
    );

    ind_xfer_lane u_lane (
        .size    (ctx_q.size),
        .addr_lo (ctx_q.addr[3:0]),
        .k       (ctx_q.k),
        .line    (ctx_q.sbuf),
        .wb_data (ln_wb),
        .wb_be   (ln_wbe),
        .st_data (ln_st),
        .st_be   (ln_sbe)
    );

    always_comb begin
        ctx_d       = ctx_q;
        instr_ready = 1'b0;
        rf_ra       = '0;
        rf_we       = 1'b0;
        rf_wa       = '0;
        rf_wd       = '0;
        rf_wbe      = '0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mmio_we     = 1'b0;
        unique case (ctx_q.st)
            S_IDLE: begin
                instr_ready = 1'b1;
                if (instr_valid) begin
                    ctx_d.offidx = instr[20:14];
                    ctx_d.inc    = instr[13:12];
                    ctx_d.dreg   = instr[11:6];
                    ctx_d.areg   = instr[5:0];
                    if (instr[31:24] == OPC_LOAD) begin
                        ctx_d.kind = K_LOAD;
                        ctx_d.size = instr[23:22];
                        ctx_d.st   = S_BASE;
                    end else if (instr[31:24] == OPC_STORE && instr[23]) begin
                        ctx_d.kind = K_STMEM;
                        ctx_d.size = instr[22:21];
                        ctx_d.st   = S_BASE;
                    end else if (instr[31:24] == OPC_STORE && instr[22]) begin
                        ctx_d.kind = K_STWIN;
                        ctx_d.size = SZ_WORD;
                        ctx_d.st   = S_BASE;
                    end
                end
            end
            S_BASE: begin
                rf_ra      = ctx_q.areg;
                ctx_d.base = rf_rd;
                ctx_d.st   = S_OFFS;
            end
            S_OFFS: begin
                rf_ra       = ctx_q.offidx[6:1];
                ctx_d.addr  = ag_addr;
                ctx_d.waddr = ag_win;
                ctx_d.k     = '0;
                if (ctx_q.inc != 2'd0) begin
                    rf_we  = 1'b1;
                    rf_wa  = ctx_q.offidx[6:1];
                    rf_wd  = {ag_next, ag_next};
                    rf_wbe = ctx_q.offidx[0] ? 4'b1100 : 4'b0011;
                end
                ctx_d.st = (ctx_q.kind == K_LOAD) ? S_ISSUE : S_DATA;
            end
            S_DATA: begin
                rf_ra = dreg_k;
                ctx_d.sbuf[{ctx_q.k, 5'b0} +: WORD_W] = rf_rd;
                if (ctx_q.size == SZ_LINE && ctx_q.k != 2'd3) begin
                    ctx_d.k = ctx_q.k + 2'd1;
                end else begin
                    ctx_d.st = S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (ctx_q.kind == K_STWIN) begin
                    mmio_we = 1'b1;
                end else begin
                    mem_req = 1'b1;
                    mem_we  = (ctx_q.kind == K_STMEM);
                end
                ctx_d.st = (ctx_q.kind == K_LOAD) ? S_WAIT : S_IDLE;
            end
            S_WAIT: begin
                if (mem_rvalid) begin
                    ctx_d.sbuf = mem_rdata;
                    ctx_d.k    = '0;
                    ctx_d.st   = S_WB;
                end
            end
            S_WB: begin
                rf_we  = 1'b1;
                rf_wa  = dreg_k;
                rf_wd  = ln_wb;
                rf_wbe = ln_wbe;
                if (ctx_q.size == SZ_LINE && ctx_q.k != 2'd3) begin
                    ctx_d.k = ctx_q.k + 2'd1;
                end else begin
                    ctx_d.st = S_IDLE;
                end
            end
            default: ctx_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q      <= '0;
            ctx_q.st   <= S_IDLE;
            ctx_q.kind <= K_LOAD;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mem_addr     = ctx_q.addr;
    assign mem_be       = ln_sbe;
    assign mem_wdata    = ln_st;
    assign mmio_addr    = ctx_q.waddr;
    assign mmio_wdata   = ctx_q.sbuf[WORD_W-1:0];
    assign load_pending = (ctx_q.st == S_WAIT) || (ctx_q.st == S_WB);
endmodule

// File: rtl/ind_xfer_unit_chk.sv
module ind_xfer_unit_chk #(
    parameter logic [31:0] WIN_BASE = 32'hFFB0_0000
) (
    input logic         clk,
    input logic         rst_n,
    input logic         instr_valid,
    input logic [31:0]  instr,
    input logic         instr_ready,
    input logic         rf_we,
    input logic         mem_req,
    input logic         mem_we,
    input logic [31:0]  mem_addr,
    input logic [15:0]  mem_be,
    input logic         mmio_we,
    input logic [31:0]  mmio_addr,
    input logic         load_pending
);
    logic real_op;
    assign real_op = instr_valid && instr_ready &&
                     (instr[31:24] == 8'h49 ||
                      (instr[31:24] == 8'h66 && (instr[23] || instr[22])));

    a_r9_min_busy: assert property (@(posedge clk) disable iff (!rst_n)
        real_op |=> !instr_ready ##1 !instr_ready ##1 !instr_ready);

    a_r10_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> load_pending);

    a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        load_pending |-> !instr_ready);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pending && !rf_we) |=> load_pending);

    a_r8_window: assert property (@(posedge clk) disable iff (!rst_n)
        mmio_we |-> ((mmio_addr | 32'h000F_FFFC) == (WIN_BASE | 32'h000F_FFFC))
                    && mmio_addr[1:0] == 2'b00);

    a_r4_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                     $countones(mem_be) == 4 || $countones(mem_be) == 16));

    a_r4_line_align: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $countones(mem_be) == 16) |-> mem_addr[3:0] == 4'h0);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mmio_we));
endmodule

bind ind_xfer_unit ind_xfer_unit_chk #(.WIN_BASE(WIN_BASE)) u_chk (.*);

// File: tb/test_ind_xfer_unit.sv
`timescale 1ns/1ps
module test_ind_xfer_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic instr_ready;
    logic [5:0] rf_ra, rf_wa;
    logic [31:0] rf_rd, rf_wd;
    logic rf_we;
    logic [3:0] rf_wbe;
    logic mem_req, mem_we, mem_rvalid;
    logic [31:0] mem_addr;
    logic [15:0] mem_be;
    logic [127:0] mem_wdata, mem_rdata;
    logic mmio_we;
    logic [31:0] mmio_addr, mmio_wdata;
    logic load_pending;

    always #4 clk = ~clk;

    ind_xfer_unit i_ind_xfer_unit (.*);

    logic [31:0] rf [0:63];
    logic [7:0]  mem [0:4095];
    int lat = 2;
    int rsp_cnt = 0;
    logic [31:0] rsp_addr = '0;
    int n_mem = 0, n_win = 0, n_rfwe = 0;
    logic [31:0] last_waddr = '0, last_wdata = '0;
    int total = 0, bad = 0, busy = 0, pend = 0;

    assign rf_rd = rf[rf_ra];

    always @(posedge clk) begin
        if (rf_we) begin
            n_rfwe <= n_rfwe + 1;
            for (int b = 0; b < 4; b++)
                if (rf_wbe[b]) rf[rf_wa][b*8 +: 8] <= rf_wd[b*8 +: 8];
        end
        if (mmio_we) begin
            n_win <= n_win + 1;
            last_waddr <= mmio_addr;
            last_wdata <= mmio_wdata;
        end
    end

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rsp_cnt != 0) begin
            rsp_cnt <= rsp_cnt - 1;
            if (rsp_cnt == 1) begin
                mem_rvalid <= 1'b1;
                for (int j = 0; j < 16; j++)
                    mem_rdata[j*8 +: 8] <= mem[{rsp_addr[11:4], j[3:0]}];
            end
        end
        if (mem_req) begin
            n_mem <= n_mem + 1;
            if (!mem_we) begin
                rsp_cnt <= lat;
                rsp_addr <= mem_addr;
            end else begin
                for (int j = 0; j < 16; j++)
                    if (mem_be[j]) mem[{mem_addr[11:4], j[3:0]}] <= mem_wdata[j*8 +: 8];
            end
        end
    end

    function automatic logic [31:0] op_ld(logic [1:0] sz, logic [7:0] off, logic [1:0] inc,
                                          logic [5:0] d, logic [5:0] a);
        return {8'h49, sz, off, inc, d, a};
    endfunction
    function automatic logic [31:0] op_st(logic [1:0] sz, logic [6:0] off, logic [1:0] inc,
                                          logic [5:0] d, logic [5:0] a);
        return {8'h66, 1'b1, sz, off, inc, d, a};
    endfunction
    function automatic logic [31:0] op_win(logic [6:0] off, logic [1:0] inc,
                                           logic [5:0] d, logic [5:0] a);
        return {8'h66, 1'b0, 1'b1, 1'b0, off, inc, d, a};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic init_rf();
        for (int i = 0; i < 64; i++) rf[i] = 32'hC0DE_0000 | i;
        rf[1] = 32'd2;
        rf[2] = 32'h0013_0005;
        rf[3] = 32'd4;
    endtask

    task automatic init_mem();
        for (int a = 0; a < 4096; a++) mem[a] = a[7:0] ^ {4'h0, a[11:8]};
    endtask

    function automatic logic [31:0] mword(int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic run_op(input logic [31:0] op);
        @(negedge clk);
        while (!instr_ready) @(negedge clk);
        instr = op;
        instr_valid = 1'b1;
        busy = 0;
        pend = 0;
        @(negedge clk);
        instr_valid = 1'b0;
        while (!instr_ready) begin
            busy++;
            if (load_pending) pend++;
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [1:0]  sz;
        logic [7:0]  off;
        logic [1:0]  inc;
        logic [5:0]  d;
        logic [5:0]  a;
        logic [5:0]  creg;
        logic [31:0] cval;
        logic [31:0] offv;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd1, 8'h04, 2'd0, 6'd10, 6'd1, 6'd10, 32'h27262524, 32'h00130005, 4'd1}, // R1 32-bit at 37->36
        '{2'd1, 8'h05, 2'd2, 6'd11, 6'd1, 6'd11, 32'h33323130, 32'h00170005, 4'd3}, // R3 high half +4
        '{2'd2, 8'h04, 2'd1, 6'd12, 6'd1, 6'd12, 32'hC0DE2524, 32'h00130007, 4'd6}, // R6 16-bit, +2
        '{2'd3, 8'h05, 2'd3, 6'd13, 6'd1, 6'd13, 32'hC0DE0033, 32'h00230005, 4'd6}, // R6 8-bit, +16
        '{2'd0, 8'h04, 2'd0, 6'd22, 6'd3, 6'd20, 32'h43424140, 32'h00130005, 4'd5}, // R5 first of four
        '{2'd0, 8'h04, 2'd0, 6'd22, 6'd3, 6'd23, 32'h4F4E4D4C, 32'h00130005, 4'd5}, // R5 last of four
        '{2'd1, 8'h84, 2'd0, 6'd14, 6'd1, 6'd14, 32'h27262524, 32'h00130005, 4'd2}, // R2 index bit 7 ignored
        '{2'd2, 8'h05, 2'd0, 6'd15, 6'd1, 6'd15, 32'hC0DE3332, 32'h00130005, 4'd4}  // R4 51 -> 50
    };

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        finish_run();
    end

    initial begin
        int m0, w0, r0;
        init_rf();
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R10, R9)
        chk("R9 reset ready", {31'b0, instr_ready}, 32'd1);
        chk("R10 reset pending", {31'b0, load_pending}, 32'd0);
        chk("R11 reset mem_req", {31'b0, mem_req}, 32'd0);
        chk("R11 reset rf_we", {31'b0, rf_we}, 32'd0);

        // table of loads: R1 R2 R3 R4 R5 R6
        foreach (VECS[i]) begin
            init_rf();
            run_op(op_ld(VECS[i].sz, VECS[i].off, VECS[i].inc, VECS[i].d, VECS[i].a));
            chk($sformatf("R%0d load vec %0d data", VECS[i].req, i), rf[VECS[i].creg], VECS[i].cval);
            chk($sformatf("R%0d load vec %0d offset", VECS[i].req, i), rf[2], VECS[i].offv);
        end

        // R3 wrap of the offset at 16 bits
        init_rf();
        rf[2] = 32'h0013_FFFE;
        run_op(op_ld(2'd1, 8'h04, 2'd3, 6'd16, 6'd1));
        chk("R3 wrap data", rf[16], 32'h1F1E1D1C);
        chk("R3 wrap offset", rf[2], 32'h0013_000E);

        // R10 pending across a long latency
        init_rf();
        lat = 6;
        run_op(op_ld(2'd1, 8'h04, 2'd0, 6'd17, 6'd1));
        chk("R10 pending cycles", {31'b0, pend >= 6}, 32'd1);
        chk("R10 pending cleared", {31'b0, load_pending}, 32'd0);
        chk("R10 data after wait", rf[17], 32'h27262524);
        lat = 2;

        // R7 local stores
        init_rf(); init_mem();
        run_op(op_st(2'd1, 7'h04, 2'd0, 6'd10, 6'd1));
        chk("R9 store busy", {31'b0, busy >= 3}, 32'd1);
        chk("R7 store word", mword(36), 32'hC0DE000A);
        chk("R7 store neighbour", {24'b0, mem[40]}, 32'h28);

        init_rf(); init_mem();
        run_op(op_st(2'd3, 7'h05, 2'd0, 6'd10, 6'd1));
        chk("R7 store byte", {24'b0, mem[51]}, 32'h0A);
        chk("R7 store byte keep", {16'b0, mem[52], mem[50]}, 32'h3432);

        init_rf(); init_mem();
        run_op(op_st(2'd2, 7'h04, 2'd2, 6'd10, 6'd1));
        chk("R7 store half", {16'b0, mem[37], mem[36]}, 32'h000A);
        chk("R7 store half keep", {24'b0, mem[38]}, 32'h26);
        chk("R3 store offset", rf[2], 32'h0013_0009);

        init_rf(); init_mem();
        run_op(op_st(2'd0, 7'h04, 2'd0, 6'd21, 6'd3));
        chk("R5 store line first", mword(64), 32'hC0DE0014);
        chk("R5 store line last", mword(76), 32'hC0DE0017);

        // R8 window store
        init_rf();
        rf[30] = 32'h1234_5678;
        rf[2]  = 32'h0013_0125;
        w0 = n_win;
        run_op(op_win(7'h04, 2'd1, 6'd10, 6'd30));
        chk("R8 window count", n_win - w0, 32'd1);
        chk("R8 window addr", last_waddr, 32'hFFB4_5688);
        chk("R8 window data", last_wdata, 32'hC0DE000A);
        chk("R8 window offset inc", rf[2], 32'h0013_0127);

        // R11 ignored opcodes
        init_rf();
        m0 = n_mem; w0 = n_win; r0 = n_rfwe;
        run_op({8'h66, 2'b00, 22'h3FFFFF});
        chk("R11 source mode busy", busy, 32'd0);
        run_op({8'h12, 24'hFFFFFF});
        repeat (10) @(negedge clk);
        chk("R11 no mem", n_mem - m0, 32'd0);
        chk("R11 no window", n_win - w0, 32'd0);
        chk("R11 no rf write", n_rfwe - r0, 32'd0);
        chk("R11 rf kept", rf[2], 32'h0013_0005);

        finish_run();
    end
endmodule